// File: doc/BRIEF.md
# Control Register High-Half Writer

This block carries out one system instruction: it copies a 32-bit general-register operand into the upper 32 bits of a 64-bit control register. The target register is named by a 5-bit register number and a 3-bit select value, both taken from the instruction word. The block checks the instruction encoding first. It then checks two permission flags. After that it either raises one of two exceptions, updates the register, or accepts the instruction and ignores it. The two page-table-entry-low registers are special: the operand is split across both halves of the register, so the update behaves as one atomic write of both halves.

The instruction side is a one-way strobe with no back-pressure. `instr_valid` qualifies `instr_word` and `gpr_data` for one cycle, and the block accepts every strobed word. Results come back one cycle later as single-cycle pulses. A preload port writes the lower halves of the registers, and a combinational read port returns any whole register, so the contents can be observed. The bank has six slots:

| Index | Register number | Select | Kind |
|---|---|---|---|
| 0 | 2 | 0 | entry-low 0 |
| 1 | 3 | 0 | entry-low 1 |
| 2 | 19 | 0 | extended |
| 3 | 17 | 0 | extended |
| 4 | 12 | 0 | implemented, not extended |
| 5 | 16 | 2 | not implemented |

Top module: `crhi_writer`

## Requirements
- R1: The block claims a word only when all of these fields match, counted from bit 31 down: bits 31:26 = 000000, bits 15:14 = 00, bits 10:6 = 01011 and bits 5:0 = 110100. The register number is bits 20:16 and the select is bits 13:11. If any of the checked fields differ, the block produces no pulse and changes no register.
- R2: A claimed word with `cp_usable` = 0 pulses `exc_unusable`. No register changes. This check takes priority over R3 and over any write.
- R3: A claimed word with `cp_usable` = 1 and `mvh_enable` = 0 pulses `exc_reserved`. No register changes.
- R4: For an implemented, extended slot that is not an entry-low register, bits 63:32 take `gpr_data` and bits 31:0 are unchanged.
- R5: For an entry-low slot with both `lpa_supported` and `lpa_enabled` set, the register is updated as follows: bits 31:30 take `gpr_data[1:0]`, bits 61:32 take the masked `gpr_data[31:2]`, bits 63:62 become 0, and bits 29:0 are unchanged.
- R6: The mask in R5 keeps the low PABITS-36 bits. PABITS is a parameter from 37 to 60, and its default of 48 gives 0xFFF.
- R7: A claimed, permitted word is accepted without any exception and without changing any register in each of these cases: the address matches no slot, the slot is not implemented, the slot is not extended, or the slot is entry-low and either large-address flag is 0.
- R8: `done`, `exc_reserved` and `exc_unusable` are registered. They rise in the cycle after the strobe edge, last exactly one cycle, and at most one of them is high at a time. `done` means the word was accepted with no exception.
- R9: Reset clears every register in the bank to zero and drops all pulses.
- R10: A preload writes bits 31:0 of the indexed slot and leaves bits 63:32 unchanged.
- R11: If a preload and an entry-low write hit the same slot on the same edge, bits 31:30 come from the instruction and bits 29:0 come from the preload.
- R12: `rd_data` shows the indexed slot combinationally, including an update made at the most recent edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| instr_valid | input | 1 | Qualifies the instruction word and operand |
| instr_word | input | 32 | Instruction word |
| gpr_data | input | 32 | Operand from the general register |
| cp_usable | input | 1 | Control-register access is permitted |
| mvh_enable | input | 1 | High-half move feature is present |
| lpa_supported | input | 1 | Large physical addressing is supported |
| lpa_enabled | input | 1 | Large physical addressing is enabled |
| pre_en | input | 1 | Preload strobe for a lower half |
| pre_idx | input | 3 | Preload slot index |
| pre_data | input | 32 | Preload value |
| rd_idx | input | 3 | Read slot index |
| rd_data | output | 64 | Contents of the slot selected by `rd_idx` |
| done | output | 1 | Word accepted with no exception (one-cycle pulse) |
| exc_reserved | output | 1 | Reserved-instruction exception (one-cycle pulse) |
| exc_unusable | output | 1 | Access-not-permitted exception (one-cycle pulse) |

## Verification
The preload port and an entry-low high-half write can land on the same register on the same edge, and both of them drive bits 31:30. The bench provokes this by strobing an entry-low instruction while it preloads that same slot, once with operand bits 1:0 set against preload bits 31:30 clear, and once the other way round. The whole register is then read back and compared: bits 31:30 must follow the instruction, and bits 29:0 must follow the preload.

// File: rtl/crhi_pkg.sv
package crhi_pkg;

  localparam int CR_COUNT = 6;
  localparam int CR_IDXW  = $clog2(CR_COUNT);

  localparam logic [5:0] OPC_MAJOR = 6'b000000;
  localparam logic [4:0] OPC_MINOR = 5'b01011;
  localparam logic [5:0] OPC_POOL  = 6'b110100;

  typedef struct packed {
    logic [4:0] regno;
    logic [2:0] sel;
  } cr_addr_t;

  typedef struct packed {
    cr_addr_t addr;
    logic     impl;
    logic     ext;
    logic     entlo;
  } cr_slot_t;

  function automatic cr_slot_t cr_slot(input int i);
    cr_slot_t s;
    case (i)
      0:       s = '{addr: '{regno: 5'd2,  sel: 3'd0}, impl: 1'b1, ext: 1'b1, entlo: 1'b1};
      1:       s = '{addr: '{regno: 5'd3,  sel: 3'd0}, impl: 1'b1, ext: 1'b1, entlo: 1'b1};
      2:       s = '{addr: '{regno: 5'd19, sel: 3'd0}, impl: 1'b1, ext: 1'b1, entlo: 1'b0};
      3:       s = '{addr: '{regno: 5'd17, sel: 3'd0}, impl: 1'b1, ext: 1'b1, entlo: 1'b0};
      4:       s = '{addr: '{regno: 5'd12, sel: 3'd0}, impl: 1'b1, ext: 1'b0, entlo: 1'b0};
      default: s = '{addr: '{regno: 5'd16, sel: 3'd2}, impl: 1'b0, ext: 1'b0, entlo: 1'b0};
    endcase
    return s;
  endfunction

endpackage

// File: rtl/crhi_decode.sv
module crhi_decode
  import crhi_pkg::*;
(
  input  logic [31:0] word,
  output logic        claim,
  output cr_addr_t    addr
);
  logic major_ok, resv_ok, minor_ok, pool_ok;

  always_comb begin
    major_ok   = (word[31:26] == OPC_MAJOR);
    resv_ok    = (word[15:14] == 2'b00);
    minor_ok   = (word[10:6]  == OPC_MINOR);
    pool_ok    = (word[5:0]   == OPC_POOL);
    claim      = major_ok && resv_ok && minor_ok && pool_ok;
    addr.regno = word[20:16];
    addr.sel   = word[13:11];
  end
endmodule

// File: rtl/crhi_lookup.sv
module crhi_lookup
  import crhi_pkg::*;
#(
  parameter int NREG = CR_COUNT,
  localparam int IDXW = $clog2(NREG)
) (
  input  cr_addr_t        addr,
  output logic            hit,
  output logic [IDXW-1:0] idx,
  output logic            impl,
  output logic            ext,
  output logic            entlo
);
  logic [NREG-1:0] match;

  for (genvar g = 0; g < NREG; g++) begin : g_cmp
    assign match[g] = (addr == cr_slot(g).addr);
  end

  always_comb begin
    hit   = 1'b0;
    idx   = '0;
    impl  = 1'b0;
    ext   = 1'b0;
    entlo = 1'b0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit   = 1'b1;
        idx   = IDXW'(i);
        impl  = cr_slot(i).impl;
        ext   = cr_slot(i).ext;
        entlo = cr_slot(i).entlo;
      end
    end
  end
endmodule

// File: rtl/crhi_bank.sv
module crhi_bank
  import crhi_pkg::*;
#(
  parameter int NREG   = CR_COUNT,
  parameter int PABITS = 48,
  localparam int IDXW  = $clog2(NREG),
  localparam logic [29:0] HI_MASK = 30'((64'd1 << (PABITS - 36)) - 64'd1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            hi_we,
  input  logic            hi_entlo,
  input  logic [IDXW-1:0] hi_idx,
  input  logic [31:0]     hi_data,
  input  logic            pre_en,
  input  logic [IDXW-1:0] pre_idx,
  input  logic [31:0]     pre_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [63:0]     rd_data
);
  logic [63:0] mem [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_slot
    logic [63:0] nxt;

    always_comb begin
      nxt = mem[g];
      if (pre_en && pre_idx == IDXW'(g)) nxt[31:0] = pre_data;
      if (hi_we && hi_idx == IDXW'(g)) begin
        if (hi_entlo) begin
          nxt[63:62] = 2'b00;
          nxt[61:32] = hi_data[31:2] & HI_MASK;
          nxt[31:30] = hi_data[1:0];
        end else begin
          nxt[63:32] = hi_data;
        end
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mem[g] <= '0;
      else        mem[g] <= nxt;
    end
  end

  assign rd_data = (int'(rd_idx) < NREG) ? mem[rd_idx] : '0;

  a_r5_top_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && hi_entlo) |=> (mem[$past(hi_idx)][63:62] == 2'b00));

  a_r4_low_half_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_we && !hi_entlo && !(pre_en && pre_idx == hi_idx))
      |=> (mem[$past(hi_idx)][31:0] == $past(mem[hi_idx][31:0])));

  a_r10_preload_upper_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en && !hi_we) |=> (mem[$past(pre_idx)][63:32] == $past(mem[pre_idx][63:32])));
endmodule

// File: rtl/crhi_writer.sv
module crhi_writer
  import crhi_pkg::*;
#(
  parameter int NREG   = CR_COUNT,
  parameter int PABITS = 48,
  localparam int IDXW  = $clog2(NREG)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            instr_valid,
  input  logic [31:0]     instr_word,
  input  logic [31:0]     gpr_data,
  input  logic            cp_usable,
  input  logic            mvh_enable,
  input  logic            lpa_supported,
  input  logic            lpa_enabled,
  input  logic            pre_en,
  input  logic [IDXW-1:0] pre_idx,
  input  logic [31:0]     pre_data,
  input  logic [IDXW-1:0] rd_idx,
  output logic [63:0]     rd_data,
  output logic            done,
  output logic            exc_reserved,
  output logic            exc_unusable
);
  logic            dec_claim;
  cr_addr_t        dec_addr;
  logic            lk_hit, lk_impl, lk_ext, lk_entlo;
  logic [IDXW-1:0] lk_idx;
  logic            claim, take_unusable, take_reserved, execute, hi_we;

  crhi_decode u_decode (
    .word  (instr_word),
    .claim (dec_claim),
    .addr  (dec_addr)
  );

  crhi_lookup #(.NREG(NREG)) u_lookup (
    .addr  (dec_addr),
    .hit   (lk_hit),
    .idx   (lk_idx),
    .impl  (lk_impl),
    .ext   (lk_ext),
    .entlo (lk_entlo)
  );

  always_comb begin
    claim         = instr_valid && dec_claim;
    take_unusable = claim && !cp_usable;
    take_reserved = claim && cp_usable && !mvh_enable;
    execute       = claim && cp_usable && mvh_enable;
    hi_we         = execute && lk_hit && lk_impl && lk_ext &&
                    (!lk_entlo || (lpa_supported && lpa_enabled));
  end

  crhi_bank #(.NREG(NREG), .PABITS(PABITS)) u_bank (
    .clk      (clk),
    .rst_n    (rst_n),
    .hi_we    (hi_we),
    .hi_entlo (lk_entlo),
    .hi_idx   (lk_idx),
    .hi_data  (gpr_data),
    .pre_en   (pre_en),
    .pre_idx  (pre_idx),
    .pre_data (pre_data),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done         <= 1'b0;
      exc_reserved <= 1'b0;
      exc_unusable <= 1'b0;
    end else begin
      done         <= execute;
      exc_reserved <= take_reserved;
      exc_unusable <= take_unusable;
    end
  end

  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, exc_reserved, exc_unusable}));

  a_r8_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !instr_valid |=> !(done || exc_reserved || exc_unusable));

  a_r2_unusable_first: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && dec_claim && !cp_usable) |=> (exc_unusable && !exc_reserved));

  a_r1_unclaimed_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (instr_valid && !dec_claim) |=> !(done || exc_reserved || exc_unusable));
endmodule

// File: tb/tb_crhi_writer.sv
module tb_crhi_writer;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 17;

  typedef struct packed {
    logic [4:0]  regno;
    logic [2:0]  sel;
    logic [1:0]  crp;     // 0 none, 1 major, 2 reserved bits, 3 pool
    logic [31:0] gpr;
    logic        cpu, mvh, lps, lpe;
    logic [2:0]  ridx;
    logic        edone, eri, ecpu;
    logic [63:0] erd;
    logic [3:0]  req;
  } vec_t;

  // Preload before the table: slot i lower half = 0x11111111 * (i+1)
  localparam vec_t VEC [NV] = '{
    '{5'd2,  3'd0, 2'd0, 32'hFFFF_FFFF, 1'b1,1'b1,1'b1,1'b1, 3'd0, 1'b1,1'b0,1'b0, 64'h0000_0FFF_D111_1111, 4'd5}, // R5 R6
    '{5'd3,  3'd0, 2'd0, 32'h0000_5006, 1'b1,1'b1,1'b1,1'b1, 3'd1, 1'b1,1'b0,1'b0, 64'h0000_0401_A222_2222, 4'd5}, // R5
    '{5'd19, 3'd0, 2'd0, 32'hDEAD_BEEF, 1'b1,1'b1,1'b0,1'b0, 3'd2, 1'b1,1'b0,1'b0, 64'hDEAD_BEEF_3333_3333, 4'd4}, // R4
    '{5'd17, 3'd0, 2'd0, 32'h1234_5678, 1'b0,1'b1,1'b0,1'b0, 3'd3, 1'b0,1'b0,1'b1, 64'h0000_0000_4444_4444, 4'd2}, // R2
    '{5'd17, 3'd0, 2'd0, 32'h1234_5678, 1'b0,1'b0,1'b0,1'b0, 3'd3, 1'b0,1'b0,1'b1, 64'h0000_0000_4444_4444, 4'd2}, // R2 priority
    '{5'd17, 3'd0, 2'd0, 32'h1234_5678, 1'b1,1'b0,1'b0,1'b0, 3'd3, 1'b0,1'b1,1'b0, 64'h0000_0000_4444_4444, 4'd3}, // R3
    '{5'd17, 3'd0, 2'd0, 32'h1234_5678, 1'b1,1'b1,1'b0,1'b0, 3'd3, 1'b1,1'b0,1'b0, 64'h1234_5678_4444_4444, 4'd4}, // R4
    '{5'd12, 3'd0, 2'd0, 32'hCAFE_F00D, 1'b1,1'b1,1'b0,1'b0, 3'd4, 1'b1,1'b0,1'b0, 64'h0000_0000_5555_5555, 4'd7}, // R7 not extended
    '{5'd16, 3'd2, 2'd0, 32'hCAFE_F00D, 1'b1,1'b1,1'b0,1'b0, 3'd5, 1'b1,1'b0,1'b0, 64'h0000_0000_6666_6666, 4'd7}, // R7 not implemented
    '{5'd5,  3'd0, 2'd0, 32'hCAFE_F00D, 1'b1,1'b1,1'b0,1'b0, 3'd2, 1'b1,1'b0,1'b0, 64'hDEAD_BEEF_3333_3333, 4'd7}, // R7 no slot
    '{5'd17, 3'd1, 2'd0, 32'hCAFE_F00D, 1'b1,1'b1,1'b0,1'b0, 3'd3, 1'b1,1'b0,1'b0, 64'h1234_5678_4444_4444, 4'd7}, // R7 select mismatch
    '{5'd2,  3'd0, 2'd0, 32'h0000_0000, 1'b1,1'b1,1'b1,1'b0, 3'd0, 1'b1,1'b0,1'b0, 64'h0000_0FFF_D111_1111, 4'd7}, // R7 lpa off
    '{5'd2,  3'd0, 2'd0, 32'h0000_0000, 1'b1,1'b1,1'b0,1'b1, 3'd0, 1'b1,1'b0,1'b0, 64'h0000_0FFF_D111_1111, 4'd7}, // R7 lpa unsupported
    '{5'd19, 3'd0, 2'd1, 32'h0000_0000, 1'b1,1'b1,1'b0,1'b0, 3'd2, 1'b0,1'b0,1'b0, 64'hDEAD_BEEF_3333_3333, 4'd1}, // R1 major
    '{5'd19, 3'd0, 2'd2, 32'h0000_0000, 1'b0,1'b0,1'b0,1'b0, 3'd2, 1'b0,1'b0,1'b0, 64'hDEAD_BEEF_3333_3333, 4'd1}, // R1 reserved bits
    '{5'd19, 3'd0, 2'd3, 32'h0000_0000, 1'b1,1'b1,1'b0,1'b0, 3'd2, 1'b0,1'b0,1'b0, 64'hDEAD_BEEF_3333_3333, 4'd1}, // R1 pool
    '{5'd2,  3'd0, 2'd0, 32'h0000_0000, 1'b1,1'b1,1'b1,1'b1, 3'd0, 1'b1,1'b0,1'b0, 64'h0000_0000_1111_1111, 4'd5}  // R5 clear
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        instr_valid = 1'b0;
  logic [31:0] instr_word = '0, gpr_data = '0;
  logic        cp_usable = 1'b0, mvh_enable = 1'b0, lpa_supported = 1'b0, lpa_enabled = 1'b0;
  logic        pre_en = 1'b0;
  logic [2:0]  pre_idx = '0, rd_idx = '0;
  logic [31:0] pre_data = '0;
  logic [63:0] rd_data;
  logic        done, exc_reserved, exc_unusable;
  int          nchk = 0, nfail = 0;
  bit          finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  crhi_writer dut (
    .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid), .instr_word(instr_word),
    .gpr_data(gpr_data), .cp_usable(cp_usable), .mvh_enable(mvh_enable),
    .lpa_supported(lpa_supported), .lpa_enabled(lpa_enabled), .pre_en(pre_en),
    .pre_idx(pre_idx), .pre_data(pre_data), .rd_idx(rd_idx), .rd_data(rd_data),
    .done(done), .exc_reserved(exc_reserved), .exc_unusable(exc_unusable)
  );

  function automatic logic [31:0] mk(input logic [4:0] regno, input logic [2:0] sel,
                                     input logic [1:0] crp);
    logic [31:0] w;
    w = {6'b000000, 5'd7, regno, 2'b00, sel, 5'b01011, 6'b110100};
    case (crp)
      2'd1: w[31:26] = 6'b000100;
      2'd2: w[15:14] = 2'b01;
      2'd3: w[5:0]   = 6'b110101;
      default: ;
    endcase
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic preload(input logic [2:0] i, input logic [31:0] d);
    @(negedge clk);
    pre_en = 1'b1; pre_idx = i; pre_data = d;
    @(posedge clk); #1;
    pre_en = 1'b0;
  endtask

  task automatic issue(input logic [31:0] w, input logic [31:0] g);
    @(negedge clk);
    instr_word = w; gpr_data = g; instr_valid = 1'b1;
    @(posedge clk); #1;
    instr_valid = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual expired expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9 reset state
    for (int i = 0; i < 6; i++) begin
      rd_idx = 3'(i); #1;
      chk(rd_data == 64'd0, "R9", "slot after reset", rd_data, 64'd0);
    end
    chk({done, exc_reserved, exc_unusable} == 3'b000, "R9", "pulses in reset",
        64'({done, exc_reserved, exc_unusable}), 64'd0);
    rst_n = 1'b1;
    for (int i = 0; i < 6; i++) preload(3'(i), 32'h1111_1111 * (i + 1));
    @(negedge clk);
    rd_idx = 3'd5; #1;
    chk(rd_data == 64'h0000_0000_6666_6666, "R10", "preload lower half", rd_data,
        64'h0000_0000_6666_6666);

    for (int k = 0; k < NV; k++) begin
      cp_usable = VEC[k].cpu; mvh_enable = VEC[k].mvh;
      lpa_supported = VEC[k].lps; lpa_enabled = VEC[k].lpe;
      rd_idx = VEC[k].ridx;
      issue(mk(VEC[k].regno, VEC[k].sel, VEC[k].crp), VEC[k].gpr);
      chk({done, exc_reserved, exc_unusable} == {VEC[k].edone, VEC[k].eri, VEC[k].ecpu},
          $sformatf("R%0d", VEC[k].req), $sformatf("vector %0d pulses", k),
          64'({done, exc_reserved, exc_unusable}),
          64'({VEC[k].edone, VEC[k].eri, VEC[k].ecpu}));
      chk(rd_data == VEC[k].erd, $sformatf("R%0d", VEC[k].req),
          $sformatf("vector %0d register", k), rd_data, VEC[k].erd);
    end

    // R8 pulse lasts one cycle
    cp_usable = 1'b1; mvh_enable = 1'b1; lpa_supported = 1'b1; lpa_enabled = 1'b1;
    issue(mk(5'd19, 3'd0, 2'd0), 32'h0000_0001);
    chk(done == 1'b1, "R8", "done after strobe", 64'(done), 64'd1);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done one cycle only", 64'(done), 64'd0);
    // R8 no strobe: legal word held without valid
    instr_word = mk(5'd19, 3'd0, 2'd0); gpr_data = 32'hFFFF_0000; rd_idx = 3'd2;
    @(negedge clk); @(negedge clk);
    chk(done == 1'b0, "R8", "no pulse without strobe", 64'(done), 64'd0);
    chk(rd_data == 64'h0000_0001_3333_3333, "R8", "no write without strobe", rd_data,
        64'h0000_0001_3333_3333);

    // R10 preload keeps upper half
    preload(3'd2, 32'h0BAD_CAFE);
    @(negedge clk);
    chk(rd_data == 64'h0000_0001_0BAD_CAFE, "R10", "upper half kept", rd_data,
        64'h0000_0001_0BAD_CAFE);

    // R11 simultaneous preload and entry-low write on slot 1
    rd_idx = 3'd1;
    @(negedge clk);
    pre_en = 1'b1; pre_idx = 3'd1; pre_data = 32'h3FFF_FFFF;
    instr_word = mk(5'd3, 3'd0, 2'd0); gpr_data = 32'h0000_0003; instr_valid = 1'b1;
    @(posedge clk); #1;
    pre_en = 1'b0; instr_valid = 1'b0;
    @(negedge clk);
    chk(rd_data == 64'h0000_0000_FFFF_FFFF, "R11", "instr bits win 31:30", rd_data,
        64'h0000_0000_FFFF_FFFF);
    pre_en = 1'b1; pre_idx = 3'd1; pre_data = 32'hC000_0000;
    instr_word = mk(5'd3, 3'd0, 2'd0); gpr_data = 32'h0000_0000; instr_valid = 1'b1;
    @(posedge clk); #1;
    pre_en = 1'b0; instr_valid = 1'b0;
    @(negedge clk);
    chk(rd_data == 64'h0000_0000_0000_0000, "R11", "preload bits 29:0 kept", rd_data,
        64'h0000_0000_0000_0000);

    // R12 read port follows index combinationally
    rd_idx = 3'd3; #1;
    chk(rd_data == 64'h1234_5678_4444_4444, "R12", "read port index change", rd_data,
        64'h1234_5678_4444_4444);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule